// File: doc/BRIEF.md
# Debug Reply Packet Formatter

This block builds the reply packets a debug stub sends back to the host over a shared serial line. It produces them one byte at a time on a valid/ready output that feeds the UART transmitter. The decoder or the run-control unit posts one request with a kind code, the replying unit's id and the operands of that kind. The formatter then emits a lead byte chosen by the kind, then the unit id, then the body. The body is a status byte and program counter, a run of data bytes read from a word memory, or a one-byte checksum.

Ordinary console text shares the same transmitter. When no reply is being sent, text bytes pass straight through. When a request is accepted, the text path is stalled from the next cycle onward, and it stays stalled until the last reply byte has been taken. A packet therefore always leaves the block as one contiguous run. Data replies pull 32-bit words from memory through a plain request/valid handshake and serialise each word low byte first.

Top module: `dbg_reply_fmt`

## Requirements
- R1: After reset, req_ready_o is 1, mem_req_o is 0, and the output carries only what the text input presents.
- R2: A request with kind 0 (status) yields exactly 5 bytes: 0xF8, the unit id zero-extended to 8 bits, the status byte, pc bits 7:0, then pc bits 15:8. All fields are captured when the request is accepted.
- R3: The status byte has the carry flag in bit 0, the inverse of the zero flag in bit 1, the 2-bit architecture code in bits 5:4 and the single-step flag in bit 7. Bits 2, 3 and 6 are 0.
- R4: A request with kind 1 (data) yields 0xF9, the unit id, then exactly req_len_i data bytes. A length of 0 yields the two header bytes only.
- R5: Data bytes come from memory words at req_addr_i, req_addr_i+1 and so on, wrapping at the address width. Each word is sent bits 7:0 first and bits 31:24 last. A final partial word sends only its lowest bytes.
- R6: A request with kind 2 or 3 (acknowledge) yields 0xFA, the unit id, then a checksum byte of 0x00.
- R7: From the cycle after a request is accepted until the cycle after its last byte is accepted, txt_ready_o is 0, and no text byte appears on the output.
- R8: req_ready_o is 0 while a reply is in progress. Requests presented in that time are not taken and do not change the reply.
- R9: While a reply byte is offered and tx_ready_i is 0, tx_valid_o stays 1 and tx_data_o does not change.
- R10: mem_req_o stays high with a steady mem_addr_o until mem_vld_i. No output byte is offered while a word is being fetched.
- R11: While no reply is in progress, tx_valid_o equals txt_valid_i, tx_data_o equals txt_data_i and txt_ready_o equals tx_ready_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Reply request valid |
| req_ready_o | output | 1 | Request accepted when high with valid |
| req_kind_i | input | 2 | 0 status, 1 data, 2 or 3 acknowledge |
| req_unit_i | input | UNIT_W (4) | Id of the replying unit |
| req_addr_i | input | ADDR_W (9) | First memory word of a data reply |
| req_len_i | input | LEN_W (8) | Data byte count |
| flag_c_i | input | 1 | Carry flag for the status byte |
| flag_z_i | input | 1 | Zero flag for the status byte |
| arch_i | input | 2 | Architecture code for the status byte |
| step_i | input | 1 | Single-step flag for the status byte |
| pc_i | input | PC_W (16) | Program counter for the status reply |
| mem_req_o | output | 1 | Word fetch request |
| mem_addr_o | output | ADDR_W (9) | Word fetch address |
| mem_vld_i | input | 1 | Fetched word valid this cycle |
| mem_data_i | input | 32 | Fetched word |
| txt_valid_i | input | 1 | Text byte valid |
| txt_data_i | input | 8 | Text byte |
| txt_ready_o | output | 1 | Text byte taken |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_ready_i | input | 1 | Transmitter takes the byte |

## Verification
The assertions assume three things about the inputs. The memory answers only while mem_req_o is high. Text data is stable within a cycle. The lead-byte properties hold only if tx_valid_o is sampled in the cycle right after acceptance. The stimulus keeps to this: the memory model raises mem_vld_i only after it sees mem_req_o, with a random delay. The transmitter's ready is random at about 75 percent. While every reply is running, the bench keeps asserting new requests with junk fields, so that the refusal and capture rules are under constant load.

// File: rtl/dbg_reply_pkg.sv
package dbg_reply_pkg;
  localparam logic [1:0] KIND_STAT = 2'd0;
  localparam logic [1:0] KIND_DATA = 2'd1;
  localparam logic [7:0] LEAD_STAT = 8'hF8;
  localparam logic [7:0] LEAD_DATA = 8'hF9;
  localparam logic [7:0] LEAD_ACK  = 8'hFA;

  typedef enum logic [2:0] {
    S_IDLE, S_LEAD, S_UNIT, S_FETCH, S_BODY
  } seq_state_e;

  function automatic logic [7:0] lead_of(input logic [1:0] kind);
    case (kind)
      KIND_STAT: lead_of = LEAD_STAT;
      KIND_DATA: lead_of = LEAD_DATA;
      default:   lead_of = LEAD_ACK;
    endcase
  endfunction
endpackage

// File: rtl/dbg_status_pack.sv
module dbg_status_pack (
  input  logic       flag_c_i,
  input  logic       flag_z_i,
  input  logic [1:0] arch_i,
  input  logic       step_i,
  output logic [7:0] stat_o
);
  always_comb begin
    stat_o      = '0;
    stat_o[0]   = flag_c_i;
    stat_o[1]   = ~flag_z_i;
    stat_o[5:4] = arch_i;
    stat_o[7]   = step_i;
  end
endmodule

// File: rtl/dbg_reply_seq.sv
module dbg_reply_seq
  import dbg_reply_pkg::*;
#(
  parameter int UNIT_W = 4,
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [UNIT_W-1:0] req_unit_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic [7:0]        stat_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_vld_i,
  input  logic [31:0]       mem_data_i,
  output logic              active_o,
  output logic              rep_valid_o,
  output logic [7:0]        rep_data_o,
  input  logic              rep_ready_i
);
  localparam int BUF_W = (PC_W + 8 > 32) ? PC_W + 8 : 32;
  localparam logic [LEN_W-1:0] STAT_REM = LEN_W'(1 + PC_W / 8);
  localparam logic [LEN_W-1:0] ACK_REM  = LEN_W'(1);

  seq_state_e        state_q, state_d;
  logic [1:0]        kind_q, kind_d;
  logic [UNIT_W-1:0] unit_q, unit_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [LEN_W-1:0]  rem_q, rem_d;
  logic [1:0]        lane_q, lane_d;
  logic [BUF_W-1:0]  buf_q, buf_d;

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    unit_d  = unit_q;
    addr_d  = addr_q;
    rem_d   = rem_q;
    lane_d  = lane_q;
    buf_d   = buf_q;
    case (state_q)
      S_IDLE: if (req_valid_i) begin
        kind_d  = req_kind_i;
        unit_d  = req_unit_i;
        addr_d  = req_addr_i;
        lane_d  = '0;
        buf_d   = '0;
        state_d = S_LEAD;
        case (req_kind_i)
          KIND_STAT: begin
            buf_d[PC_W+7:0] = {pc_i, stat_i};
            rem_d = STAT_REM;
          end
          KIND_DATA: rem_d = req_len_i;
          default:   rem_d = ACK_REM;
        endcase
      end
      S_LEAD: if (rep_ready_i) state_d = S_UNIT;
      S_UNIT: if (rep_ready_i) begin
        if (rem_q == '0)            state_d = S_IDLE;
        else if (kind_q == KIND_DATA) state_d = S_FETCH;
        else                        state_d = S_BODY;
      end
      S_FETCH: if (mem_vld_i) begin
        buf_d        = '0;
        buf_d[31:0]  = mem_data_i;
        addr_d       = addr_q + 1'b1;
        lane_d       = '0;
        state_d      = S_BODY;
      end
      S_BODY: if (rep_ready_i) begin
        buf_d  = buf_q >> 8;
        rem_d  = rem_q - 1'b1;
        lane_d = lane_q + 1'b1;
        if (rem_q == LEN_W'(1))                          state_d = S_IDLE;
        else if (kind_q == KIND_DATA && lane_q == 2'd3)  state_d = S_FETCH;
      end
      default: state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      kind_q  <= '0;
      unit_q  <= '0;
      addr_q  <= '0;
      rem_q   <= '0;
      lane_q  <= '0;
      buf_q   <= '0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      unit_q  <= unit_d;
      addr_q  <= addr_d;
      rem_q   <= rem_d;
      lane_q  <= lane_d;
      buf_q   <= buf_d;
    end
  end

  always_comb begin
    rep_valid_o = 1'b0;
    rep_data_o  = '0;
    case (state_q)
      S_LEAD: begin rep_valid_o = 1'b1; rep_data_o = lead_of(kind_q); end
      S_UNIT: begin rep_valid_o = 1'b1; rep_data_o = 8'(unit_q); end
      S_BODY: begin rep_valid_o = 1'b1; rep_data_o = buf_q[7:0]; end
      default: ;
    endcase
  end

  assign req_ready_o = (state_q == S_IDLE);
  assign active_o    = (state_q != S_IDLE);
  assign mem_req_o   = (state_q == S_FETCH);
  assign mem_addr_o  = addr_q;
endmodule

// File: rtl/dbg_out_arb.sv
module dbg_out_arb #(
  parameter int DATA_W = 8
) (
  input  logic              active_i,
  input  logic              rep_valid_i,
  input  logic [DATA_W-1:0] rep_data_i,
  input  logic              txt_valid_i,
  input  logic [DATA_W-1:0] txt_data_i,
  output logic              txt_ready_o,
  output logic              tx_valid_o,
  output logic [DATA_W-1:0] tx_data_o,
  input  logic              tx_ready_i
);
  // reply owns the line for its whole length, even while fetching
  always_comb begin
    if (active_i) begin
      tx_valid_o  = rep_valid_i;
      tx_data_o   = rep_data_i;
      txt_ready_o = 1'b0;
    end else begin
      tx_valid_o  = txt_valid_i;
      tx_data_o   = txt_data_i;
      txt_ready_o = tx_ready_i;
    end
  end
endmodule

// File: rtl/dbg_reply_fmt.sv
module dbg_reply_fmt #(
  parameter int UNIT_W = 4,
  parameter int ADDR_W = 9,
  parameter int LEN_W  = 8,
  parameter int PC_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [1:0]        req_kind_i,
  input  logic [UNIT_W-1:0] req_unit_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [LEN_W-1:0]  req_len_i,
  input  logic              flag_c_i,
  input  logic              flag_z_i,
  input  logic [1:0]        arch_i,
  input  logic              step_i,
  input  logic [PC_W-1:0]   pc_i,
  output logic              mem_req_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  input  logic              mem_vld_i,
  input  logic [31:0]       mem_data_i,
  input  logic              txt_valid_i,
  input  logic [7:0]        txt_data_i,
  output logic              txt_ready_o,
  output logic              tx_valid_o,
  output logic [7:0]        tx_data_o,
  input  logic              tx_ready_i
);
  logic [7:0] stat;
  logic       active;
  logic       rep_valid;
  logic [7:0] rep_data;

  dbg_status_pack i_stat (
    .flag_c_i (flag_c_i),
    .flag_z_i (flag_z_i),
    .arch_i   (arch_i),
    .step_i   (step_i),
    .stat_o   (stat)
  );

  dbg_reply_seq #(
    .UNIT_W (UNIT_W),
    .ADDR_W (ADDR_W),
    .LEN_W  (LEN_W),
    .PC_W   (PC_W)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .req_ready_o (req_ready_o),
    .req_kind_i  (req_kind_i),
    .req_unit_i  (req_unit_i),
    .req_addr_i  (req_addr_i),
    .req_len_i   (req_len_i),
    .stat_i      (stat),
    .pc_i        (pc_i),
    .mem_req_o   (mem_req_o),
    .mem_addr_o  (mem_addr_o),
    .mem_vld_i   (mem_vld_i),
    .mem_data_i  (mem_data_i),
    .active_o    (active),
    .rep_valid_o (rep_valid),
    .rep_data_o  (rep_data),
    .rep_ready_i (tx_ready_i)
  );

  dbg_out_arb #(.DATA_W(8)) i_arb (
    .active_i    (active),
    .rep_valid_i (rep_valid),
    .rep_data_i  (rep_data),
    .txt_valid_i (txt_valid_i),
    .txt_data_i  (txt_data_i),
    .txt_ready_o (txt_ready_o),
    .tx_valid_o  (tx_valid_o),
    .tx_data_o   (tx_data_o),
    .tx_ready_i  (tx_ready_i)
  );
endmodule

// File: rtl/dbg_reply_fmt_chk.sv
module dbg_reply_fmt_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       req_valid_i,
  input logic       req_ready_o,
  input logic [1:0] req_kind_i,
  input logic       mem_req_o,
  input logic       txt_valid_i,
  input logic [7:0] txt_data_i,
  input logic       txt_ready_o,
  input logic       tx_valid_o,
  input logic [7:0] tx_data_o,
  input logic       tx_ready_i
);
  p_lead_stat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_kind_i == 2'd0 |=> tx_valid_o && tx_data_o == 8'hF8);
  p_lead_data_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_kind_i == 2'd1 |=> tx_valid_o && tx_data_o == 8'hF9);
  p_lead_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o && req_kind_i[1] |=> tx_valid_o && tx_data_o == 8'hFA);
  p_no_text_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o |-> !txt_ready_o);
  p_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i && req_ready_o |=> !req_ready_o);
  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_ready_o && tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));
  p_fetch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !req_ready_o && !tx_valid_o);
  p_pass_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> tx_valid_o == txt_valid_i && txt_ready_o == tx_ready_i &&
                    (!txt_valid_i || tx_data_o == txt_data_i));
endmodule

bind dbg_reply_fmt dbg_reply_fmt_chk i_chk (.*);

// File: tb/test_dbg_reply_fmt.sv
module test_dbg_reply_fmt;
  localparam int UNIT_W = 4;
  localparam int ADDR_W = 9;
  localparam int LEN_W  = 8;
  localparam int PC_W   = 16;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic              rst_n;
  logic              req_valid, req_ready;
  logic [1:0]        req_kind;
  logic [UNIT_W-1:0] req_unit;
  logic [ADDR_W-1:0] req_addr;
  logic [LEN_W-1:0]  req_len;
  logic              fc, fz, stp;
  logic [1:0]        arch;
  logic [PC_W-1:0]   pc;
  logic              mem_req, mem_vld;
  logic [ADDR_W-1:0] mem_addr;
  logic [31:0]       mem_data;
  logic              txt_valid, txt_ready;
  logic [7:0]        txt_data;
  logic              tx_valid, tx_ready;
  logic [7:0]        tx_data;

  dbg_reply_fmt i_dbg_reply_fmt (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_kind_i(req_kind),
    .req_unit_i(req_unit), .req_addr_i(req_addr), .req_len_i(req_len),
    .flag_c_i(fc), .flag_z_i(fz), .arch_i(arch), .step_i(stp), .pc_i(pc),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr), .mem_vld_i(mem_vld), .mem_data_i(mem_data),
    .txt_valid_i(txt_valid), .txt_data_i(txt_data), .txt_ready_o(txt_ready),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_ready_i(tx_ready)
  );

  int checks = 0;
  int errors = 0;
  logic [7:0] got[$];
  logic [7:0] exp[$];
  logic [7:0] txt_cnt = 8'h20;
  bit leak, hold_bad, fetch_bad, prev_stall;
  logic [7:0] prev_byte;

  function automatic logic [31:0] word_of(input logic [ADDR_W-1:0] a);
    word_of = {a[7:0] + 8'h11, ~a[7:0], a[7:0] ^ 8'hC3, {7'd0, a[8]} ^ 8'h80};
  endfunction

  function automatic logic [7:0] stat_of(input logic c, input logic z,
                                          input logic [1:0] ar, input logic s);
    stat_of = {s, 1'b0, ar, 2'b00, ~z, c};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic text_adv();
    if (txt_valid && txt_ready && tx_ready)
      txt_cnt = (txt_cnt == 8'h7E) ? 8'h20 : txt_cnt + 8'd1;
  endtask

  // one cycle of a running reply; returns 1 once the block is idle again
  task automatic cycle(output bit idle);
    @(negedge clk);
    tx_ready  = ($urandom % 4) != 0;
    txt_valid = $urandom % 2;
    txt_data  = txt_cnt;
    mem_vld   = 1'b0;
    #1;
    if (mem_req && ($urandom % 3) != 0) begin
      mem_vld  = 1'b1;
      mem_data = word_of(mem_addr);
    end
    idle = req_ready;
    if (!idle) begin
      if (txt_ready) leak = 1'b1;
      if (mem_req && tx_valid) fetch_bad = 1'b1;
      if (prev_stall && !(tx_valid && tx_data == prev_byte)) hold_bad = 1'b1;
      if (tx_valid && tx_ready) got.push_back(tx_data);
      prev_stall = tx_valid && !tx_ready;
      prev_byte  = tx_data;
      // junk request while busy (R8)
      req_valid = 1'b1;
      req_kind  = 2'($urandom);
      req_unit  = UNIT_W'($urandom);
      req_addr  = ADDR_W'($urandom);
      req_len   = LEN_W'($urandom);
      pc        = PC_W'($urandom);
      {fc, fz, stp, arch} = 5'($urandom);
    end else begin
      req_valid  = 1'b0;
      prev_stall = 1'b0;
    end
    text_adv();
  endtask

  task automatic run_req(input logic [1:0] k, input logic [UNIT_W-1:0] u,
                         input logic [ADDR_W-1:0] a, input logic [LEN_W-1:0] n,
                         input logic c, input logic z, input logic [1:0] ar,
                         input logic s, input logic [PC_W-1:0] p);
    bit idle;
    string tag;
    int guard;
    @(negedge clk);
    req_valid = 1'b1; req_kind = k; req_unit = u; req_addr = a; req_len = n;
    fc = c; fz = z; arch = ar; stp = s; pc = p;
    tx_ready  = ($urandom % 4) != 0;
    txt_valid = $urandom % 2;
    txt_data  = txt_cnt;
    mem_vld   = 1'b0;
    #1;
    check(req_ready == 1'b1, "R8", "ready while idle", req_ready, 1);
    text_adv();
    exp.delete(); got.delete();
    leak = 0; hold_bad = 0; fetch_bad = 0; prev_stall = 0;
    case (k)
      2'd0: begin
        exp.push_back(8'hF8); exp.push_back(8'(u));
        exp.push_back(stat_of(c, z, ar, s)); exp.push_back(p[7:0]); exp.push_back(p[15:8]);
        tag = "R2 R3";
      end
      2'd1: begin
        exp.push_back(8'hF9); exp.push_back(8'(u));
        for (int i = 0; i < int'(n); i++) begin
          logic [31:0] w;
          w = word_of(a + ADDR_W'(i / 4));
          exp.push_back(w[8*(i%4) +: 8]);
        end
        tag = "R4 R5";
      end
      default: begin
        exp.push_back(8'hFA); exp.push_back(8'(u)); exp.push_back(8'h00);
        tag = "R6";
      end
    endcase
    cycle(idle);
    check(!idle, "R8", "ready after accept", idle, 0);
    guard = 0;
    while (!idle && guard < 5000) begin
      cycle(idle);
      guard++;
    end
    check(got.size() == exp.size(), tag, "reply length", got.size(), exp.size());
    begin
      int bad = -1;
      for (int i = 0; i < got.size() && i < exp.size(); i++)
        if (bad < 0 && got[i] !== exp[i]) bad = i;
      if (bad >= 0) check(1'b0, tag, $sformatf("byte %0d", bad), got[bad], exp[bad]);
      else          check(1'b1, tag, "bytes", 0, 0);
    end
    check(!leak, "R7", "text ready during reply", leak, 0);
    check(!hold_bad, "R9", "byte changed under stall", hold_bad, 0);
    check(!fetch_bad, "R10", "byte offered during fetch", fetch_bad, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    rst_n = 1'b0; req_valid = 0; req_kind = 0; req_unit = 0; req_addr = 0; req_len = 0;
    fc = 0; fz = 0; arch = 0; stp = 0; pc = 0; mem_vld = 0; mem_data = 0;
    txt_valid = 0; txt_data = 0; tx_ready = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(req_ready == 1'b1, "R1", "req_ready after reset", req_ready, 1);
    check(mem_req == 1'b0, "R1", "mem_req after reset", mem_req, 0);
    check(tx_valid == 1'b0, "R1", "tx_valid after reset", tx_valid, 0);

    // R11: idle passthrough
    begin
      bit bad = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        tx_ready = $urandom % 2; txt_valid = $urandom % 2; txt_data = txt_cnt;
        #1;
        if (tx_valid !== txt_valid || txt_ready !== tx_ready ||
            (txt_valid && tx_data !== txt_data)) bad = 1;
        text_adv();
      end
      check(!bad, "R11", "idle passthrough", bad, 0);
    end

    // directed corners
    run_req(2'd0, 4'd3, '0, '0, 1'b1, 1'b1, 2'd1, 1'b0, 16'hBEEF); // R3 carry, Z set
    run_req(2'd0, 4'd0, '0, '0, 1'b0, 1'b0, 2'd2, 1'b1, 16'h0102); // R3 step, !Z
    run_req(2'd1, 4'd7, 9'd5, 8'd0, 0, 0, 0, 0, 0);                // R4 empty
    run_req(2'd1, 4'd1, 9'd16, 8'd1, 0, 0, 0, 0, 0);               // R5 partial
    run_req(2'd1, 4'd2, 9'd16, 8'd4, 0, 0, 0, 0, 0);               // R5 one word
    run_req(2'd1, 4'd9, 9'd510, 8'd11, 0, 0, 0, 0, 0);             // R5 wrap
    run_req(2'd2, 4'd14, '0, '0, 0, 0, 0, 0, 0);                   // R6
    run_req(2'd3, 4'd15, '0, '0, 0, 0, 0, 0, 0);                   // R6 kind 3

    for (int r = 0; r < 40; r++)
      run_req(2'($urandom), UNIT_W'($urandom), ADDR_W'($urandom), LEN_W'($urandom % 40),
              1'($urandom), 1'($urandom), 2'($urandom), 1'($urandom), PC_W'($urandom));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule